// File: doc/BRIEF.md
# Vertical Reference Delay and Acquisition Line Counter

This block sits at the front of a video acquisition path. Both of its reference inputs are sampled in the pixel clock domain: a vertical sync reference and a horizontal clamp reference. The rising edge of the vertical reference is moved later by a programmable number of pixel clock periods. The delayed event then does three things. It starts a new field. It presets a line counter. It opens a half-line window that decides whether the field is odd or even. Moving the vertical event lets the integrator place it clear of the clamp pulses, so that the parity decision is never ambiguous.

The line counter advances once per horizontal clamp rising edge. It tells downstream memory control which line of the field is being acquired. A standard-select input sets the first processed line. In the enhanced wide-screen mode this is line 24. In the normal mode it is line 21. The block flags that line, and it also flags every line from there to the end of the field.

Top module: `vref_line_timer`

## Requirements
- R1: While reset is low, and at the first sample after reset is released, `vedge_dly_o`, `field_even_o`, `first_line_o` and `active_line_o` are 0 and `line_cnt_o` is 0.
- R2: Each rising edge of `vsync_in` is first seen at some clock edge E, and the delay value D is in `delay_cfg`. `vedge_dly_o` is then high for exactly one cycle, the cycle that follows clock edge E+D. With D = 0 this is the cycle right after E.
- R3: Suppose another `vsync_in` rising edge is seen while an earlier delayed pulse is still pending. The pending pulse is then dropped and never appears. Timing restarts from the newer edge.
- R4: At every clock edge where `vedge_dly_o` is high, `line_cnt_o` becomes 1. This happens even if a clamp rising edge is seen at the same clock edge.
- R5: At any other clock edge, a rising edge of `clamp_in` adds 1 to `line_cnt_o`. Holding `clamp_in` high for several cycles counts only once.
- R6: `line_cnt_o` saturates at 1023. Further clamp rising edges leave it at 1023 until the next delayed vertical pulse.
- R7: `first_line_o` is high exactly when `line_cnt_o` equals 24 with `wide_std` = 1, or 21 with `wide_std` = 0. `active_line_o` is high when `line_cnt_o` is at or above that value. Both follow `wide_std` combinationally.
- R8: Let J be the clock edge that takes `vedge_dly_o` high. At clock edge J+HALF_LINE, `field_even_o` is loaded with 1 if a clamp rising edge was seen at any edge from J through J+HALF_LINE, and with 0 otherwise. At all other times it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vsync_in | input | 1 | Vertical reference, already synchronous to clk |
| clamp_in | input | 1 | Horizontal clamp reference, already synchronous to clk |
| delay_cfg | input | 8 | Vertical delay in clock periods, 0 means no delay |
| wide_std | input | 1 | 1 selects enhanced wide-screen standard (first line 24), 0 normal (first line 21) |
| vedge_dly_o | output | 1 | One-cycle pulse marking the delayed vertical event |
| field_even_o | output | 1 | 1 when the current field was judged even |
| line_cnt_o | output | 10 | Acquisition line number within the field |
| first_line_o | output | 1 | High on the first processed line |
| active_line_o | output | 1 | High on the first processed line and every later line |

## Verification
The bench times the delayed pulse with delay 0 and with a non-zero delay. A counter that is off by one moves the pulse a cycle early or late. A second vertical edge that arrives while a pulse is pending must suppress the earlier pulse. A design that keeps both would fire twice, or fire at the old time. A clamp edge that lands on the same clock edge as the delayed vertical pulse must leave the counter at 1, not 2, and must count toward an even field. The bench also holds the clamp high over several cycles, which a level-sensitive counter would count more than once. It runs the counter into saturation, where a wrapping counter would return to 0. It switches the standard in the middle of a line, to catch a first-line flag that was decoded late.

// File: rtl/vref_pkg.sv
// Package: shared constants and types for the vertical reference line timer.
// Assumes: line numbers are counted from 1 at the delayed vertical event.
package vref_pkg;

    // Input standard encoding as seen on the wide_std pin.
    typedef enum logic {
        STD_NORMAL = 1'b0,
        STD_WIDE   = 1'b1
    } vref_std_e;

    // First processed line for each standard.
    localparam int FIRST_LINE_NORMAL = 21;
    localparam int FIRST_LINE_WIDE   = 24;

    // Return the first processed line for a given standard.
    function automatic int first_line_of(input vref_std_e std);
        return (std == STD_WIDE) ? FIRST_LINE_WIDE : FIRST_LINE_NORMAL;
    endfunction

endpackage

// File: rtl/vref_edge_det.sv
// Module: rising-edge detector for a vector of synchronous inputs.
// Each bit keeps one registered copy. A rise is reported combinationally
// while the current sample is 1 and the stored sample is 0.
// Assumes: the inputs are already synchronous to clk.
module vref_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        // Store the previous sample of one input bit.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= sig_i[g];
        end
        // Report a 0-to-1 transition of the same bit.
        assign rise_o[g] = sig_i[g] & ~prev_q[g];
    end

endmodule

// File: rtl/vref_delay.sv
// Module: programmable delay for a single trigger pulse.
// With a delay of 0 the output pulse follows the trigger by one register.
// A delay of D adds D more cycles. A new trigger reloads the counter and
// so drops any pulse still waiting.
// Assumes: trig_i is a one-cycle pulse. dly_i is stable while a pulse is pending.
module vref_delay #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             fire_o
);

    logic [DLY_W-1:0] cnt_q;
    logic             pend_q;

    // Count down from the programmed delay and fire once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            fire_o <= 1'b0;
        end else begin
            fire_o <= 1'b0;
            if (trig_i) begin
                if (dly_i == '0) begin
                    fire_o <= 1'b1;
                    pend_q <= 1'b0;
                end else begin
                    cnt_q  <= dly_i;
                    pend_q <= 1'b1;
                end
            end else if (pend_q) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == DLY_W'(1)) begin
                    fire_o <= 1'b1;
                    pend_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/vref_parity.sv
// Module: odd/even field decision.
// A window opens on the delayed vertical pulse and lasts HALF_LINE clock
// edges after it. If a clamp rise falls in the window, the field is even.
// Assumes: the delayed vertical event is placed well away from the clamp
// edges, so that the window result is unambiguous.
module vref_parity #(
    parameter int HALF_LINE = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic clamp_rise_i,
    output logic even_o
);

    localparam int WIN_W = $clog2(HALF_LINE + 1);

    logic [WIN_W-1:0] win_q;
    logic             act_q;
    logic             seen_q;

    // Run the window and latch the parity at its last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q  <= '0;
            act_q  <= 1'b0;
            seen_q <= 1'b0;
            even_o <= 1'b0;
        end else if (start_i) begin
            win_q  <= WIN_W'(HALF_LINE);
            act_q  <= 1'b1;
            seen_q <= clamp_rise_i;
        end else if (act_q) begin
            win_q  <= win_q - 1'b1;
            seen_q <= seen_q | clamp_rise_i;
            if (win_q == WIN_W'(1)) begin
                even_o <= seen_q | clamp_rise_i;
                act_q  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/vref_line_ctr.sv
// Module: saturating acquisition line counter.
// A preset loads 1 and takes priority. Otherwise each increment request adds
// one, until the counter reaches its maximum value.
// Assumes: preset_i and incr_i are one-cycle pulses.
module vref_line_ctr #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preset_i,
    input  logic              incr_i,
    output logic [LINE_W-1:0] cnt_o
);

    localparam logic [LINE_W-1:0] CNT_MAX = '1;

    // Preset, advance or hold the line number.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt_o <= '0;
        else if (preset_i)                    cnt_o <= LINE_W'(1);
        else if (incr_i && cnt_o != CNT_MAX)  cnt_o <= cnt_o + 1'b1;
    end

endmodule

// File: rtl/vref_line_timer.sv
// Module: top of the vertical reference delay and line counter.
// Detects the reference edges and delays the vertical one. Decides field
// parity, counts lines and flags the processed range for the selected standard.
// Assumes: vsync_in and clamp_in are synchronous to clk, and delay_cfg is
// loaded by logic outside this block.
module vref_line_timer
    import vref_pkg::*;
#(
    parameter int DLY_W     = 8,
    parameter int LINE_W    = 10,
    parameter int HALF_LINE = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_in,
    input  logic              clamp_in,
    input  logic [DLY_W-1:0]  delay_cfg,
    input  logic              wide_std,
    output logic              vedge_dly_o,
    output logic              field_even_o,
    output logic [LINE_W-1:0] line_cnt_o,
    output logic              first_line_o,
    output logic              active_line_o
);

    localparam int N_REF = 2;

    logic [N_REF-1:0]  ref_rise;
    logic              v_rise;
    logic              c_rise;
    logic [LINE_W-1:0] first_val;

    vref_edge_det #(.N(N_REF)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  ({clamp_in, vsync_in}),
        .rise_o (ref_rise)
    );

    assign v_rise = ref_rise[0];
    assign c_rise = ref_rise[1];

    vref_delay #(.DLY_W(DLY_W)) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (v_rise),
        .dly_i  (delay_cfg),
        .fire_o (vedge_dly_o)
    );

    vref_parity #(.HALF_LINE(HALF_LINE)) u_parity (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (vedge_dly_o),
        .clamp_rise_i (c_rise),
        .even_o       (field_even_o)
    );

    vref_line_ctr #(.LINE_W(LINE_W)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset_i (vedge_dly_o),
        .incr_i   (c_rise),
        .cnt_o    (line_cnt_o)
    );

    // Pick the first processed line for the selected standard.
    always_comb begin
        first_val = LINE_W'(first_line_of(vref_std_e'(wide_std)));
    end

    assign first_line_o  = (line_cnt_o == first_val);
    assign active_line_o = (line_cnt_o >= first_val);

endmodule

// File: rtl/vref_line_timer_chk.sv
// Checker: temporal properties of vref_line_timer, bound into every instance.
module vref_line_timer_chk #(
    parameter int DLY_W  = 8,
    parameter int LINE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              v_rise,
    input logic              c_rise,
    input logic [DLY_W-1:0]  delay_cfg,
    input logic              vedge_dly_o,
    input logic [LINE_W-1:0] line_cnt_o,
    input logic              first_line_o,
    input logic              active_line_o
);

    localparam logic [LINE_W-1:0] LMAX = '1;

    assert_vdly_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vedge_dly_o |=> !vedge_dly_o);

    assert_zero_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (v_rise && delay_cfg == '0) |=> vedge_dly_o);

    assert_preset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vedge_dly_o |=> line_cnt_o == LINE_W'(1));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!vedge_dly_o && !c_rise) |=> $stable(line_cnt_o));

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!vedge_dly_o && c_rise && line_cnt_o != LMAX)
        |=> line_cnt_o == $past(line_cnt_o) + LINE_W'(1));

    assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!vedge_dly_o && line_cnt_o == LMAX) |=> line_cnt_o == LMAX);

    assert_first_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        first_line_o |-> active_line_o);

endmodule

bind vref_line_timer vref_line_timer_chk #(.DLY_W(DLY_W), .LINE_W(LINE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .v_rise        (v_rise),
    .c_rise        (c_rise),
    .delay_cfg     (delay_cfg),
    .vedge_dly_o   (vedge_dly_o),
    .line_cnt_o    (line_cnt_o),
    .first_line_o  (first_line_o),
    .active_line_o (active_line_o)
);

// File: tb/sim_vref_line_timer.sv
module sim_vref_line_timer;

    localparam int HALF = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vsync_in = 1'b0;
    logic       clamp_in = 1'b0;
    logic [7:0] delay_cfg = '0;
    logic       wide_std = 1'b0;
    logic       vedge_dly_o, field_even_o, first_line_o, active_line_o;
    logic [9:0] line_cnt_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        string req;
        int    sel;   // 0 line, 1 even, 2 first, 3 active, 4 vdly
        int    exp;
    } item_t;

    item_t q[$];
    event  chk_ev;

    always #10 clk = ~clk;

    vref_line_timer #(.HALF_LINE(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .clamp_in(clamp_in),
        .delay_cfg(delay_cfg), .wide_std(wide_std), .vedge_dly_o(vedge_dly_o),
        .field_even_o(field_even_o), .line_cnt_o(line_cnt_o),
        .first_line_o(first_line_o), .active_line_o(active_line_o)
    );

    function automatic int pick(int sel);
        case (sel)
            0: return int'(line_cnt_o);
            1: return int'(field_even_o);
            2: return int'(first_line_o);
            3: return int'(active_line_o);
            default: return int'(vedge_dly_o);
        endcase
    endfunction

    // Monitor: pops expected items and compares them with the outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                int act;
                it = q.pop_front();
                act = pick(it.sel);
                n_chk++;
                if (act != it.exp) begin
                    n_fail++;
                    $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(string req, int sel, int exp);
        q.push_back('{req, sel, exp});
        -> chk_ev;
        #1;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clamp_pulse();
        clamp_in = 1'b1; tick(1);
        clamp_in = 1'b0; tick(1);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Driver: stimulus plus expected values.
    initial begin
        tick(3);
        expect_val("R1 line in reset", 0, 0);
        expect_val("R1 vdly in reset", 4, 0);
        rst_n = 1'b1;
        tick(1);
        expect_val("R1 line after reset", 0, 0);
        expect_val("R1 even after reset", 1, 0);
        expect_val("R1 first after reset", 2, 0);
        expect_val("R1 active after reset", 3, 0);

        // Zero delay, no clamp in window: odd field.
        delay_cfg = 8'd0;
        vsync_in = 1'b1;
        tick(1);
        expect_val("R2 zero delay pulse", 4, 1);
        tick(1);
        expect_val("R2 pulse one cycle", 4, 0);
        expect_val("R4 preset line", 0, 1);
        tick(HALF + 4);
        expect_val("R8 odd without clamp", 1, 0);

        // Clamp rise together with delayed pulse: preset wins, field even.
        vsync_in = 1'b0; tick(2);
        vsync_in = 1'b1; tick(1);
        expect_val("R2 pulse for priority case", 4, 1);
        clamp_in = 1'b1; tick(1);
        clamp_in = 1'b0;
        expect_val("R4 preset beats clamp", 0, 1);
        tick(HALF + 4);
        expect_val("R8 even with clamp at window start", 1, 1);

        // Delay of 5, then counting through the processed range.
        vsync_in = 1'b0; tick(2);
        delay_cfg = 8'd5;
        vsync_in = 1'b1;
        tick(5);
        expect_val("R2 no pulse before delay", 4, 0);
        tick(1);
        expect_val("R2 pulse after delay 5", 4, 1);
        tick(1);
        expect_val("R4 preset after delay", 0, 1);
        for (int i = 0; i < 19; i++) clamp_pulse();
        expect_val("R5 count 20", 0, 20);
        expect_val("R7 not first at 20", 2, 0);
        expect_val("R7 not active at 20", 3, 0);
        clamp_in = 1'b1; tick(5);
        clamp_in = 1'b0; tick(1);
        expect_val("R5 held clamp counts once", 0, 21);
        expect_val("R7 first line normal", 2, 1);
        expect_val("R7 active at 21", 3, 1);
        clamp_pulse();
        expect_val("R7 not first at 22", 2, 0);
        expect_val("R7 active at 22", 3, 1);
        wide_std = 1'b1; #1;
        expect_val("R7 wide inactive at 22", 3, 0);
        clamp_pulse(); clamp_pulse();
        expect_val("R7 wide first line 24", 2, 1);
        expect_val("R7 wide active at 24", 3, 1);
        expect_val("R8 even kept", 1, 1);
        for (int i = 0; i < 999; i++) clamp_pulse();
        expect_val("R6 reaches 1023", 0, 1023);
        clamp_pulse(); clamp_pulse();
        expect_val("R6 saturates", 0, 1023);

        // Restart while pending: only the later edge fires.
        vsync_in = 1'b0; tick(2);
        delay_cfg = 8'd10;
        vsync_in = 1'b1;
        for (int i = 1; i <= 17; i++) begin
            tick(1);
            expect_val("R3 pending pulse dropped", 4, (i == 17) ? 1 : 0);
            if (i == 4) vsync_in = 1'b0;
            if (i == 6) vsync_in = 1'b1;
        end
        tick(1);
        expect_val("R4 preset from saturation", 0, 1);
        tick(HALF + 4);
        expect_val("R8 odd after restart", 1, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule